// File: doc/BRIEF.md
# Video Stream Frame Capture

This block sits beside a video timing and pixel generator and records what that generator actually puts out, so that a checker can compare the picture with what was intended. It samples horizontal sync, vertical sync, a colour-enable qualifier and separate red, green and blue fields, all on the pixel clock. It follows a write cursor (column x, row y) and stores every qualified pixel as a packed 32-bit word in an internal frame store of WIDTH by HEIGHT words.

Line and frame boundaries are not derived from timing counts. A falling edge of horizontal sync starts a new row, but only if something was written on the current row. A falling edge of vertical sync sends the cursor back to row 0 and raises a one-cycle frame-done pulse. Both coordinates stop at the image edge and never wrap. Writes that would land outside the image are dropped. The checker reads stored words back through a synchronous read port addressed by column and row. For a standard 640 by 480 picture, set the size parameters to those values. The defaults are kept smaller so that the store stays modest.

Top module: `vga_frame_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, pos_x_o and pos_y_o are 0 and frame_done_o is 0. The stored previous levels of both syncs are 0, so a sync that is high right after reset is not an edge.
- R2: In each cycle with color_en_i high, the pixel word is written at the current (x, y), and x then advances by one.
- R3: The stored word is red shifted left by 19, OR green shifted left by 10, OR blue shifted left by 3, and all other bits are 0. With the default 5/6/5 fields, full red is 0x00F80000, full green is 0x0000FC00 and full blue is 0x000000F8.
- R4: A horizontal sync falling edge (sampled high, now low) while x is not 0 sets x to 0 and advances y by one.
- R5: A horizontal sync falling edge while x is 0 leaves x and y unchanged. A rising edge or a steady level of either sync has no effect.
- R6: A vertical sync falling edge sets y to 0 and leaves x alone. frame_done_o is high for exactly the one cycle that follows that edge.
- R7: x stops at WIDTH. Enabled pixels while x equals WIDTH write nothing, so the next row's words are not disturbed.
- R8: y stops at HEIGHT. Enabled pixels while y equals HEIGHT write nothing, and a further line advance leaves y at HEIGHT.
- R9: When events coincide in one cycle, they apply in this order: vertical reset of y, then line advance, then the pixel write at the resulting coordinates and the x increment.
- R10: rd_data_o presents the word stored at (rd_x_i, rd_y_i) one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync level |
| vsync_i | input | 1 | Vertical sync level |
| color_en_i | input | 1 | Active-video qualifier for the colour fields |
| red_i | input | RED_W | Red component |
| green_i | input | GRN_W | Green component |
| blue_i | input | BLU_W | Blue component |
| rd_x_i | input | XW | Read column |
| rd_y_i | input | YW | Read row |
| rd_data_o | output | 32 | Stored word, one cycle after the read address |
| frame_done_o | output | 1 | One-cycle pulse after a vertical sync falling edge |
| pos_x_o | output | XW | Current write column (0..WIDTH) |
| pos_y_o | output | YW | Current write row (0..HEIGHT) |

## Verification
The two functions that can land in the same cycle are the sync-driven cursor moves and the pixel write. The most demanding case is a single cycle in which vertical sync falls, horizontal sync falls with x non-zero, and colour-enable is high. The bench drives exactly that combination, and then a vertical edge together with a pixel but no line edge. It judges the result from the reported cursor and from the word read back at the coordinates that the ordering predicts. A scoreboard model of the whole frame store also shows that no other location was touched.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
   localparam int PIX_W   = 32;
   localparam int RED_LSB = 19;
   localparam int GRN_LSB = 10;
   localparam int BLU_LSB = 3;
   typedef logic [PIX_W-1:0] pixel_word_t;
endpackage

// File: rtl/vfc_sync_edge.sv
module vfc_sync_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (rst) prev_q[i] <= 1'b0;
         else     prev_q[i] <= lvl[i];
      end
      assign fall[i] = prev_q[i] & ~lvl[i];
   end
endmodule

// File: rtl/vfc_cursor.sv
module vfc_cursor #(
   parameter int WIDTH  = 64,
   parameter int HEIGHT = 48,
   parameter int XW     = 7,
   parameter int YW     = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          vfall,
   input  logic          hfall,
   input  logic          pix_en,
   output logic [XW-1:0] x_o,
   output logic [YW-1:0] y_o,
   output logic          wr_en_o,
   output logic [XW-1:0] wr_x_o,
   output logic [YW-1:0] wr_y_o
);
   localparam logic [XW-1:0] X_END = XW'(WIDTH);
   localparam logic [YW-1:0] Y_END = YW'(HEIGHT);

   logic [XW-1:0] x_q, x_b, x_n;
   logic [YW-1:0] y_q, y_a, y_b;
   logic          adv;

   always_comb begin
      y_a = vfall ? '0 : y_q;
      adv = hfall && (x_q != '0);
      if (adv) begin
         y_b = (y_a == Y_END) ? y_a : y_a + 1'b1;
         x_b = '0;
      end else begin
         y_b = y_a;
         x_b = x_q;
      end
      if (pix_en) x_n = (x_b == X_END) ? x_b : x_b + 1'b1;
      else        x_n = x_b;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         x_q <= x_n;
         y_q <= y_b;
      end
   end

   assign wr_en_o = pix_en && (x_b < X_END) && (y_b < Y_END);
   assign wr_x_o  = x_b;
   assign wr_y_o  = y_b;
   assign x_o     = x_q;
   assign y_o     = y_q;
endmodule

// File: rtl/vfc_frame_store.sv
module vfc_frame_store #(
   parameter int DEPTH = 3072,
   parameter int AW    = 12,
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rd <= mem[ra];
   end
endmodule

// File: rtl/vga_frame_capture.sv
module vga_frame_capture
   import vfc_pkg::*;
#(
   parameter int WIDTH  = 64,
   parameter int HEIGHT = 48,
   parameter int RED_W  = 5,
   parameter int GRN_W  = 6,
   parameter int BLU_W  = 5,
   parameter int XW     = $clog2(WIDTH + 1),
   parameter int YW     = $clog2(HEIGHT + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hsync_i,
   input  logic             vsync_i,
   input  logic             color_en_i,
   input  logic [RED_W-1:0] red_i,
   input  logic [GRN_W-1:0] green_i,
   input  logic [BLU_W-1:0] blue_i,
   input  logic [XW-1:0]    rd_x_i,
   input  logic [YW-1:0]    rd_y_i,
   output logic [31:0]      rd_data_o,
   output logic             frame_done_o,
   output logic [XW-1:0]    pos_x_o,
   output logic [YW-1:0]    pos_y_o
);
   localparam int DEPTH = WIDTH * HEIGHT;
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (WIDTH < 1 || HEIGHT < 1) begin : g_bad_size
      $error("frame size must be at least one pixel");
   end
   if (RED_W + RED_LSB > PIX_W || GRN_W + GRN_LSB > RED_LSB || BLU_W + BLU_LSB > GRN_LSB) begin : g_bad_fields
      $error("colour fields overlap in the packed word");
   end
   if (XW < $clog2(WIDTH + 1) || YW < $clog2(HEIGHT + 1)) begin : g_bad_coord
      $error("coordinate width too small for saturation value");
   end

   logic [1:0]    sync_fall;
   logic          wr_en;
   logic [XW-1:0] wr_x;
   logic [YW-1:0] wr_y;
   logic [AW-1:0] wr_addr, rd_addr;
   pixel_word_t   pix_word, rd_word;
   logic          done_q;

   vfc_sync_edge #(.N(2)) i_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  ({vsync_i, hsync_i}),
      .fall (sync_fall)
   );

   vfc_cursor #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .XW(XW), .YW(YW)) i_cursor (
      .clk     (clk),
      .rst     (rst),
      .vfall   (sync_fall[1]),
      .hfall   (sync_fall[0]),
      .pix_en  (color_en_i),
      .x_o     (pos_x_o),
      .y_o     (pos_y_o),
      .wr_en_o (wr_en),
      .wr_x_o  (wr_x),
      .wr_y_o  (wr_y)
   );

   always_comb begin
      pix_word = (pixel_word_t'(red_i)   << RED_LSB)
               | (pixel_word_t'(green_i) << GRN_LSB)
               | (pixel_word_t'(blue_i)  << BLU_LSB);
      wr_addr  = AW'(wr_y)   * AW'(WIDTH) + AW'(wr_x);
      rd_addr  = AW'(rd_y_i) * AW'(WIDTH) + AW'(rd_x_i);
   end

   vfc_frame_store #(.DEPTH(DEPTH), .AW(AW), .DW(PIX_W)) i_store (
      .clk (clk),
      .we  (wr_en),
      .wa  (wr_addr),
      .wd  (pix_word),
      .ra  (rd_addr),
      .rd  (rd_word)
   );

   always_ff @(posedge clk) begin
      if (rst) done_q <= 1'b0;
      else     done_q <= sync_fall[1];
   end

   assign frame_done_o = done_q;
   assign rd_data_o    = rd_word;
endmodule

// File: rtl/vfc_checker.sv
module vfc_checker #(
   parameter int WIDTH  = 64,
   parameter int HEIGHT = 48,
   parameter int XW     = 7,
   parameter int YW     = 6
) (
   input logic          clk,
   input logic          rst,
   input logic          hsync,
   input logic          vsync,
   input logic          color_en,
   input logic          frame_done,
   input logic [XW-1:0] pos_x,
   input logic [YW-1:0] pos_y
);
   a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
      (color_en && !$fell(hsync) && pos_x < XW'(WIDTH)) |=> pos_x == XW'($past(pos_x) + 1'b1));

   a_r4_line_advance: assert property (@(posedge clk) disable iff (rst)
      ($fell(hsync) && pos_x != '0) |=> pos_x <= XW'(1));

   a_r5_empty_line_ignored: assert property (@(posedge clk) disable iff (rst)
      ($fell(hsync) && pos_x == '0 && !$fell(vsync)) |=> $stable(pos_y));

   a_r6_done_follows_edge: assert property (@(posedge clk) disable iff (rst)
      $fell(vsync) |=> frame_done);

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> !frame_done);

   a_r9_done_row: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> pos_y <= YW'(1));

   a_r7_x_saturates: assert property (@(posedge clk) disable iff (rst)
      pos_x <= XW'(WIDTH));

   a_r8_y_saturates: assert property (@(posedge clk) disable iff (rst)
      pos_y <= YW'(HEIGHT));
endmodule

bind vga_frame_capture vfc_checker #(
   .WIDTH(WIDTH), .HEIGHT(HEIGHT), .XW(XW), .YW(YW)
) i_vfc_checker (
   .clk        (clk),
   .rst        (rst),
   .hsync      (hsync_i),
   .vsync      (vsync_i),
   .color_en   (color_en_i),
   .frame_done (frame_done_o),
   .pos_x      (pos_x_o),
   .pos_y      (pos_y_o)
);

// File: tb/test_vga_frame_capture.sv
`timescale 1ns/1ps
module test_vga_frame_capture;
   localparam int W  = 8;
   localparam int H  = 4;
   localparam int XW = $clog2(W + 1);
   localparam int YW = $clog2(H + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          hs = 1'b0, vs = 1'b0, en = 1'b0;
   logic [4:0]    red = '0, blu = '0;
   logic [5:0]    grn = '0;
   logic [XW-1:0] rx = '0;
   logic [YW-1:0] ry = '0;
   logic [31:0]   rdat;
   logic          done;
   logic [XW-1:0] px;
   logic [YW-1:0] py;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [31:0] model_mem [W*H];
   int  ex = 0, ey = 0;
   logic ph = 1'b0, pv = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_req = 1'b0;

   always #5 clk = ~clk;

   vga_frame_capture #(.WIDTH(W), .HEIGHT(H)) i_vga_frame_capture (
      .clk          (clk),
      .rst          (rst),
      .hsync_i      (hs),
      .vsync_i      (vs),
      .color_en_i   (en),
      .red_i        (red),
      .green_i      (grn),
      .blue_i       (blu),
      .rd_x_i       (rx),
      .rd_y_i       (ry),
      .rd_data_o    (rdat),
      .frame_done_o (done),
      .pos_x_o      (px),
      .pos_y_o      (py)
   );

   function automatic logic [31:0] pk(input logic [4:0] r, input logic [5:0] g, input logic [4:0] b);
      return {8'h00, r, 3'b000, g, 2'b00, b, 3'b000};
   endfunction

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // one pixel-clock vector; called at a falling clock edge
   task automatic vec(input logic h, input logic v, input logic e,
                      input logic [4:0] r, input logic [5:0] g, input logic [4:0] b,
                      input string tag);
      logic vf, hf, exp_done;
      hs = h; vs = v; en = e; red = r; grn = g; blu = b;
      vf = pv & ~v;
      hf = ph & ~h;
      pv = v; ph = h;
      if (vf) ey = 0;
      if (hf && ex != 0) begin
         ey = (ey == H) ? H : ey + 1;
         ex = 0;
      end
      if (e) begin
         if (ex < W && ey < H) model_mem[ey*W + ex] = pk(r, g, b);
         ex = (ex == W) ? W : ex + 1;
      end
      exp_done = vf;
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (int'(px) != ex || int'(py) != ey || done !== exp_done) begin
         fails++;
         $display("FAIL %s: x=%0d y=%0d done=%b, expected x=%0d y=%0d done=%b",
                  tag, px, py, done, ex, ey, exp_done);
      end
   endtask

   task automatic idle(input logic h, input logic v, input string tag);
      vec(h, v, 1'b0, 5'd0, 6'd0, 5'd0, tag);
   endtask

   // scoreboard driver: queue the expected word, present the address
   task automatic rd(input int x, input int y, input logic [31:0] expv, input string tag);
      rx = XW'(x); ry = YW'(y);
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      rd_req = 1'b1;
      @(negedge clk);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         logic pend;
         @(posedge clk);
         pend = rd_req;
         @(negedge clk);
         if (pend) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdat !== e) begin
               fails++;
               $display("FAIL %s: read 0x%08h, expected 0x%08h", t, rdat, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
   end

   initial begin
      int k;
      for (int i = 0; i < W*H; i++) model_mem[i] = '0;
      repeat (3) @(posedge clk);
      // R1: inside reset
      @(negedge clk);
      checks++;
      if (px !== '0 || py !== '0 || done !== 1'b0) begin
         fails++;
         $display("FAIL R1: x=%0d y=%0d done=%b, expected 0 0 0", px, py, done);
      end
      rst = 1'b0;
      // R1 after release: syncs rise, no edge
      idle(1'b1, 1'b1, "R1");
      idle(1'b1, 1'b1, "R5");

      // frame 1: full picture
      idle(1'b1, 1'b0, "R6");
      idle(1'b1, 1'b1, "R6");
      for (int y = 0; y < H; y++) begin
         for (int x = 0; x < W; x++) begin
            int n;
            n = y*W + x;
            vec(1'b1, 1'b1, 1'b1, 5'(n), 6'(n*3), 5'(31 - n), "R2");
         end
         idle(1'b0, 1'b1, "R4");
         idle(1'b1, 1'b1, "R4");
      end
      // y is now H: writes dropped, advance held
      vec(1'b1, 1'b1, 1'b1, 5'h11, 6'h22, 5'h13, "R8");
      vec(1'b1, 1'b1, 1'b1, 5'h12, 6'h23, 5'h14, "R8");
      idle(1'b0, 1'b1, "R8");
      idle(1'b1, 1'b1, "R8");
      // line edge with x at 0 is ignored
      idle(1'b0, 1'b1, "R5");
      idle(1'b1, 1'b1, "R5");

      // frame 2
      idle(1'b1, 1'b0, "R6");
      idle(1'b1, 1'b1, "R6");
      vec(1'b1, 1'b1, 1'b1, 5'h03, 6'h07, 5'h09, "R2");
      idle(1'b0, 1'b1, "R4");
      idle(1'b1, 1'b1, "R4");
      vec(1'b1, 1'b1, 1'b1, 5'h0C, 6'h0D, 5'h0E, "R2");
      vec(1'b1, 1'b1, 1'b1, 5'h00, 6'h3F, 5'h00, "R3");
      vec(1'b1, 1'b1, 1'b1, 5'h00, 6'h00, 5'h1F, "R3");
      vec(1'b1, 1'b1, 1'b1, 5'h1F, 6'h00, 5'h00, "R3");
      idle(1'b0, 1'b1, "R4");
      idle(1'b1, 1'b1, "R4");
      vec(1'b1, 1'b1, 1'b1, 5'h15, 6'h2A, 5'h0A, "R2");
      idle(1'b0, 1'b1, "R4");
      idle(1'b1, 1'b1, "R4");
      // last row, overrun by two pixels
      k = 0;
      for (int x = 0; x < W + 2; x++) begin
         vec(1'b1, 1'b1, 1'b1, 5'(k + 7), 6'(k + 40), 5'(k + 2), "R7");
         k++;
      end
      idle(1'b0, 1'b1, "R7");
      idle(1'b1, 1'b1, "R7");

      // R9: coincident events
      vec(1'b1, 1'b1, 1'b1, 5'h01, 6'h01, 5'h01, "R8");
      vec(1'b0, 1'b0, 1'b1, 5'h1A, 6'h1B, 5'h1C, "R9");
      idle(1'b1, 1'b1, "R9");
      vec(1'b1, 1'b0, 1'b1, 5'h05, 6'h06, 5'h07, "R9");
      idle(1'b1, 1'b1, "R9");

      // readback through the scoreboard
      rd(1, 1, 32'h0000_FC00, "R3");
      rd(2, 1, 32'h0000_00F8, "R3");
      rd(3, 1, 32'h00F8_0000, "R3");
      rd(0, 1, pk(5'h1A, 6'h1B, 5'h1C), "R9");
      rd(1, 0, pk(5'h05, 6'h06, 5'h07), "R9");
      for (int a = 0; a < W*H; a++) rd(a % W, a / W, model_mem[a], "R10");
      rd_req = 1'b0;
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R10: %0d reads outstanding, expected 0", exp_q.size());
      end
      report();
   end
endmodule